// File: doc/BRIEF.md
# Scalable Single-Input-Change Codeword Generator

This block produces Johnson-style codewords for a bank of parallel scan chains. It does not hold an l-bit Johnson register. It keeps two small counters of width k = ceil(log2(l+1)), where l is the scan length. A load counter advances once per scan load. It counts 0, 1, ..., l and then starts again at 0. When a load begins, its value sets how many 1s the serial source emits in that load.

While scan-enable is low, a down-counter copies the load counter on every clock. While scan-enable is high, the down-counter steps towards zero once per clock and then stays at zero. The serial bit is 1 while shifting and the down-counter is nonzero. Otherwise it is 0, and a polarity parameter swaps the two levels. The serial bit feeds an M-bit shift register, and each of its cells drives one scan chain. After a full load of l clocks, neighbouring chains hold codewords that differ by one shift position.

The block runs on one clock. The rising edge of scan-enable is found by comparing the input with its value at the previous clock edge.

Top module: `sic_codeword_gen`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), every bit of `chain_bits` sits at the idle level: 0 when INVERT=0 and 1 when INVERT=1. The load counter starts at 0.
- R2: The load counter advances by one at each clock edge where `scan_en` is 1 and was 0 at the previous edge. At every other edge it holds its value.
- R3: When the load counter equals SCAN_LEN and advances, it returns to 0. Load number p after reset (counting from 0) therefore uses the value p mod (SCAN_LEN+1).
- R4: At each clock edge where `scan_en` is 0, the down-counter takes the load counter's value. The first shift clock of a load therefore sees the value in force before that load's own advance.
- R5: At each clock edge where `scan_en` is 1, a nonzero down-counter decreases by one. A zero down-counter stays at zero and never wraps.
- R6: The serial bit is 1 when `scan_en` is 1 and the down-counter is nonzero, and 0 otherwise. INVERT=1 swaps these levels. In a load with value c, shift clock j (counting from 0) carries a 1 exactly when j < c.
- R7: At each clock edge where `scan_en` is 1, `chain_bits[i]` takes `chain_bits[i-1]` and `chain_bits[0]` takes the serial bit. At each edge where `scan_en` is 0, `chain_bits` holds its value.
- R8: After a load of exactly SCAN_LEN shift clocks with value c, `chain_bits[i]` is 1 exactly when i >= SCAN_LEN - c (complemented for INVERT=1).
- R9: If `scan_en` stays high for more than SCAN_LEN clocks, the extra shift clocks carry the 0 level, even when the load began at c = SCAN_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | High during a shift phase, low between loads |
| chain_bits | output | CHAINS | One codeword bit per scan chain; bit 0 is the newest serial bit |

## Verification
The assertions take `scan_en` to be synchronous to `clk` and stable around each rising edge. They also take reset to be applied once before the first shift phase, so that the edge register, the counters and the shift register start from known values. The stimulus changes `scan_en` only at falling clock edges and holds it low when reset is released. It keeps at least one low cycle between shift phases, so the down-counter always reloads before a phase starts. Phase lengths include full loads, a short load and an over-long load, so the counter wrap, the saturation at zero and the codeword shape are all reached inside those limits.

// File: rtl/sic_pkg.sv
`timescale 1ns/1ps
package sic_pkg;

  // Counter width able to hold 0..len inclusive.
  function automatic int unsigned cnt_width(input int unsigned len);
    return (len < 1) ? 1 : $clog2(len + 1);
  endfunction

  // Next load value: advance by one, return to zero after the limit.
  function automatic int unsigned wrap_next(input int unsigned cur,
                                            input int unsigned lim);
    return (cur >= lim) ? 0 : cur + 1;
  endfunction

  // Saturating decrement: zero stays zero.
  function automatic int unsigned sat_dec(input int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

endpackage

// File: rtl/sic_rise_detect.sv
`timescale 1ns/1ps
module sic_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  // 0-to-1 change since the previous edge
  assign rise = level_in & ~level_q;
endmodule

// File: rtl/sic_load_ctr.sv
`timescale 1ns/1ps
module sic_load_ctr #(
  parameter int unsigned K     = 4,
  parameter int unsigned LIMIT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [K-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (adv) q <= K'(sic_pkg::wrap_next(32'(q), LIMIT));
  end
endmodule

// File: rtl/sic_down_ctr.sv
`timescale 1ns/1ps
module sic_down_ctr #(
  parameter int unsigned K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic [K-1:0] load_val,
  output logic [K-1:0] q,
  output logic         nonzero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (!shift_en) q <= load_val;
    else                q <= K'(sic_pkg::sat_dec(32'(q)));
  end

  assign nonzero = |q;
endmodule

// File: rtl/sic_chain_shift.sv
`timescale 1ns/1ps
module sic_chain_shift #(
  parameter int unsigned W    = 8,
  parameter bit          IDLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         serial_in,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic d;
    logic r;
    if (i == 0) begin : g_head
      assign d = serial_in;
    end else begin : g_body
      assign d = q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  r <= IDLE;
      else if (en) r <= d;
    end

    assign q[i] = r;
  end
endmodule

// File: rtl/sic_codeword_gen.sv
`timescale 1ns/1ps
module sic_codeword_gen #(
  parameter int unsigned CHAINS   = 8,
  parameter int unsigned SCAN_LEN = 64,
  parameter bit          INVERT   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  output logic [CHAINS-1:0] chain_bits
);
  localparam int unsigned K = sic_pkg::cnt_width(SCAN_LEN);

  // Internal events, named for the bound checker
  logic         se_rise;
  logic [K-1:0] load_cnt;
  logic [K-1:0] down_cnt;
  logic         down_nz;
  logic         serial_bit;

  sic_rise_detect u_rise (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (scan_en),
    .rise     (se_rise)
  );

  sic_load_ctr #(.K(K), .LIMIT(SCAN_LEN)) u_load (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (se_rise),
    .q     (load_cnt)
  );

  sic_down_ctr #(.K(K)) u_down (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (scan_en),
    .load_val (load_cnt),
    .q        (down_cnt),
    .nonzero  (down_nz)
  );

  assign serial_bit = (scan_en & down_nz) ^ INVERT;

  sic_chain_shift #(.W(CHAINS), .IDLE(INVERT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (scan_en),
    .serial_in (serial_bit),
    .q         (chain_bits)
  );
endmodule

// File: rtl/sic_codeword_chk.sv
`timescale 1ns/1ps
module sic_codeword_chk #(
  parameter int unsigned CHAINS   = 8,
  parameter int unsigned SCAN_LEN = 64,
  parameter bit          INVERT   = 1'b0,
  parameter int unsigned K        = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_en,
  input logic              se_rise,
  input logic [K-1:0]      load_cnt,
  input logic [K-1:0]      down_cnt,
  input logic [CHAINS-1:0] chain_bits
);
  localparam logic [K-1:0] LMAX = K'(SCAN_LEN);

  assert_adv_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (se_rise && load_cnt != LMAX) |=> load_cnt == K'($past(load_cnt) + 1'b1));

  assert_adv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !se_rise |=> $stable(load_cnt));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (se_rise && load_cnt == LMAX) |=> load_cnt == '0);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> down_cnt == $past(load_cnt));

  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && down_cnt != '0) |=> down_cnt == K'($past(down_cnt) - 1'b1));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && down_cnt == '0) |=> down_cnt == '0);

  assert_serial_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && down_cnt != '0) |=> chain_bits[0] == ~INVERT);

  assert_serial_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && down_cnt == '0) |=> chain_bits[0] == INVERT);

  assert_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> chain_bits[CHAINS-1:1] == $past(chain_bits[CHAINS-2:0]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(chain_bits));
endmodule

bind sic_codeword_gen sic_codeword_chk #(
  .CHAINS(CHAINS), .SCAN_LEN(SCAN_LEN), .INVERT(INVERT), .K(K)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scan_en    (scan_en),
  .se_rise    (se_rise),
  .load_cnt   (load_cnt),
  .down_cnt   (down_cnt),
  .chain_bits (chain_bits)
);

// File: tb/test_sic_codeword_gen.sv
`timescale 1ns/1ps
module test_sic_codeword_gen;
  localparam int CH = 6;
  localparam int SL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0;
  logic [CH-1:0] bits_pos;
  logic [CH-1:0] bits_neg;

  always #2.5 clk = ~clk;

  sic_codeword_gen #(.CHAINS(CH), .SCAN_LEN(SL), .INVERT(1'b0)) i_sic_codeword_gen (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chain_bits(bits_pos));

  sic_codeword_gen #(.CHAINS(CH), .SCAN_LEN(SL), .INVERT(1'b1)) i_sic_codeword_gen_inv (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chain_bits(bits_neg));

  typedef struct {
    logic [CH-1:0] exp;
    string         tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [CH-1:0] exp_sr = '0;
  int pidx = 0;

  task automatic check(input string tag, input logic [CH-1:0] act,
                       input logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: chain_bits=%b expected %b", tag, act, exp);
    end
  endtask

  // Driver: one clock step, pushes the expected state after the edge.
  task automatic step(input logic se, input int cval, input int j,
                      input string tag);
    @(negedge clk);
    scan_en = se;
    if (se) exp_sr = {exp_sr[CH-2:0], logic'(j < cval)};
    sbq.push_back('{exp_sr, tag});
  endtask

  // One load: nlow idle clocks, then nhigh shift clocks.
  task automatic run_phase(input int nlow, input int nhigh);
    int cval;
    string tag;
    cval = pidx % (SL + 1);          // R3: load value wraps after SL
    for (int i = 0; i < nlow; i++) step(1'b0, cval, 0, "R7");
    for (int j = 0; j < nhigh; j++) begin
      if (j == 0)            tag = "R4";
      else if (j == 1)       tag = "R2";
      else if (j == SL - 1)  tag = (pidx > SL) ? "R3" : "R8";
      else if (j >= SL)      tag = "R9";
      else if (j < cval)     tag = "R6";
      else                   tag = "R5";
      step(1'b1, cval, j, tag);
    end
    pidx++;
  endtask

  // Monitor: compares both polarities just after each rising edge.
  always @(posedge clk) begin
    item_t it;
    #1;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      check(it.tag, bits_pos, it.exp);
      check({it.tag, " inverted R6"}, bits_neg, ~it.exp);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", bits_pos, '0);
    check("R1 inverted", bits_neg, '1);
    rst_n = 1'b1;
    for (int p = 0; p < 13; p++) begin
      if (p == 10)     run_phase(2, SL + 3);   // R9: c = SL, over-long load
      else if (p == 4) run_phase(3, 4);        // short load still advances
      else             run_phase((p % 3 == 0) ? 1 : 3, SL);
    end
    step(1'b0, 0, 0, "R7");
    step(1'b0, 0, 0, "R7");
    wait (sbq.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule